// File: doc/BRIEF.md
# Dual-Event Counter with Snapshot Registers

This block counts two selectable events out of a wide vector of single-cycle event strobes. Examples are link messages received or posted requests sent. Each of the two counters has its own selector code. The selector picks which bit of the event vector increments that counter. Software runs a measurement window through one control register. It writes clear-plus-start, waits as long as it likes, then writes stop-plus-snapshot. That final write freezes both counters and copies their values into shadow registers.

Every counter is wider than a 32-bit register. The low part of each shadow value is read from a register of its own. The high part sits in a read-only field of the event-control register, next to the two selector fields. The full count is therefore `low | (high << 32)` with default parameters. Every read returns shadow values, never the live counters. A snapshot cannot tear and stays fixed until the next shadow load.

Top module: `dual_evt_ctr`

## Requirements
- R1: After reset, both live counters, both shadows, both selectors and the enable are zero. All four registers read as zero, and `regRvalid` is low.
- R2: Each cycle, a counter adds exactly one if counting is enabled and the event input indexed by its selector code is high. Events sampled while counting is disabled add nothing.
- R3: A selector code of `NUM_EVENTS` or above never increments its counter, whatever the event vector holds.
- R4: Count-control (address 0) bit 0 enables both counters. A write with bit 0 clear and bit 1 clear stops counting and leaves both live counts unchanged.
- R5: Count-control bit 2 zeroes both live counters in the cycle after the write. When written together with bit 0 (value 0x5), events count from the cycle after the write.
- R6: Count-control bit 1 copies both counts into the shadows. The copy includes any event counted at the same clock edge. Writing 0x2 stops counting and captures in one write.
- R7: Address 2 returns the low `LOW_W` bits of counter 0's shadow, and address 3 returns those of counter 1. The shadows stay unchanged while the live counts advance, until the next bit-1 write.
- R8: Reading count-control returns the enable in bit 0. Bits 1 and 2 act as single-cycle pulses and always read as zero.
- R9: Event-control (address 1) holds selector 0 in bits [7:0] and selector 1 in bits [15:8]. A write changes only these two fields. The shadow high bits, read-only, appear in bits [23:16] for counter 0 and bits [31:24] for counter 1.
- R10: Read data is valid, with `regRvalid` high, exactly one cycle after a `regRd` strobe. `regRvalid` stays high for that one cycle only.
- R11: Each counter is `LOW_W+UP_W` bits wide. Counts carry from the low register into the high field and wrap to zero after the all-ones value.
- R12: The two counters are independent. Each counts only its own selected event, and both count in the same cycle when both of their events are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | NUM_EVENTS | Event strobes, one bit per event code |
| regAddr | input | 2 | Register address: 0 count-control, 1 event-control, 2 count 0 low, 3 count 1 low |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRd | input | 1 | Read strobe |
| regRdata | output | 32 | Read data, valid with regRvalid |
| regRvalid | output | 1 | High one cycle after regRd |

## Verification
A live counter that misses, double-counts or wraps wrongly stays hidden until the next shadow load. At that point it shows up at the ports as a wrong low word or high field, read one cycle after the read strobe. A shadow that follows the live count instead of holding shows up on the first read after the counters move on. A clear that arrives a cycle late, or a wrong-edge capture, shows up as a count off by exactly one. For this reason the directed scenarios place events right at the start and stop writes. A stuck enable or selector shows up on the very next control-register or event-control read.

// File: rtl/dual_evt_ctr_pkg.sv
package dual_evt_ctr_pkg;
  localparam int SEL_W  = 8;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EVT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LOW0 = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_LOW1 = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic             clearAll;
    logic             loadShadow;
    logic             countEn;
    logic [SEL_W-1:0] sel0;
    logic [SEL_W-1:0] sel1;
  } ctlStrobes_t;
endpackage

// File: rtl/dual_evt_ctr_lane.sv
module dual_evt_ctr_lane
  import dual_evt_ctr_pkg::*;
#(
  parameter int NUM_EVENTS = 128,
  parameter int CNT_W      = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] evtIn,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  countEn,
  input  logic                  clearAll,
  input  logic                  loadShadow,
  output logic [CNT_W-1:0]      shadowCnt
);
  logic             hit;
  logic [CNT_W-1:0] liveCnt;
  logic [CNT_W-1:0] nextCnt;

  // selector decode: out-of-range codes never match
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_EVENTS; i++) begin
      if (int'(sel) == i) hit = evtIn[i];
    end
  end

  always_comb begin
    if (clearAll)            nextCnt = '0;
    else if (countEn && hit) nextCnt = liveCnt + 1'b1;
    else                     nextCnt = liveCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCnt   <= '0;
      shadowCnt <= '0;
    end else begin
      liveCnt <= nextCnt;
      if (loadShadow) shadowCnt <= nextCnt;
    end
  end

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!clearAll && countEn && hit) |=> liveCnt == $past(liveCnt) + 1'b1);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!clearAll && !countEn) |=> $stable(liveCnt));

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> liveCnt == '0);

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !loadShadow |=> $stable(shadowCnt));
endmodule

// File: rtl/dual_evt_ctr_dp.sv
module dual_evt_ctr_dp
  import dual_evt_ctr_pkg::*;
#(
  parameter int NUM_EVENTS = 128,
  parameter int CNT_W      = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] evtIn,
  input  ctlStrobes_t           strobes,
  output logic [CNT_W-1:0]      shadow0,
  output logic [CNT_W-1:0]      shadow1
);
  localparam int NUM_LANES = 2;

  logic [SEL_W-1:0] laneSel    [NUM_LANES];
  logic [CNT_W-1:0] laneShadow [NUM_LANES];

  assign laneSel[0] = strobes.sel0;
  assign laneSel[1] = strobes.sel1;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    dual_evt_ctr_lane #(
      .NUM_EVENTS(NUM_EVENTS),
      .CNT_W     (CNT_W)
    ) u_lane (
      .clk       (clk),
      .rstN      (rstN),
      .evtIn     (evtIn),
      .sel       (laneSel[g]),
      .countEn   (strobes.countEn),
      .clearAll  (strobes.clearAll),
      .loadShadow(strobes.loadShadow),
      .shadowCnt (laneShadow[g])
    );
  end

  assign shadow0 = laneShadow[0];
  assign shadow1 = laneShadow[1];
endmodule

// File: rtl/dual_evt_ctr_ctrl.sv
module dual_evt_ctr_ctrl
  import dual_evt_ctr_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int LOW_W = 32,
  parameter int UP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              regRd,
  input  logic [CNT_W-1:0]  shadow0,
  input  logic [CNT_W-1:0]  shadow1,
  output ctlStrobes_t       strobes,
  output logic [REG_W-1:0]  regRdata,
  output logic              regRvalid
);
  logic             enReg;
  logic [SEL_W-1:0] sel0Reg;
  logic [SEL_W-1:0] sel1Reg;
  logic             ctlWrite;
  logic             evtWrite;
  logic [REG_W-1:0] rdMux;
  logic             unusedWdata;

  assign ctlWrite    = regWr && (regAddr == ADDR_CTL);
  assign evtWrite    = regWr && (regAddr == ADDR_EVT);
  assign unusedWdata = ^regWdata[REG_W-1:2*SEL_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      sel0Reg <= '0;
      sel1Reg <= '0;
    end else begin
      if (ctlWrite) enReg <= regWdata[0];
      if (evtWrite) begin
        sel0Reg <= regWdata[SEL_W-1:0];
        sel1Reg <= regWdata[2*SEL_W-1:SEL_W];
      end
    end
  end

  // clear and load are single-cycle pulses straight from the write
  always_comb begin
    strobes.clearAll   = ctlWrite && regWdata[2];
    strobes.loadShadow = ctlWrite && regWdata[1];
    strobes.countEn    = enReg;
    strobes.sel0       = sel0Reg;
    strobes.sel1       = sel1Reg;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTL:  rdMux = REG_W'(enReg);
      ADDR_EVT:  rdMux = {SEL_W'(shadow1[CNT_W-1:LOW_W]),
                          SEL_W'(shadow0[CNT_W-1:LOW_W]),
                          sel1Reg, sel0Reg};
      ADDR_LOW0: rdMux = REG_W'(shadow0[LOW_W-1:0]);
      default:   rdMux = REG_W'(shadow1[LOW_W-1:0]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata  <= '0;
      regRvalid <= 1'b0;
    end else begin
      regRvalid <= regRd;
      if (regRd) regRdata <= rdMux;
    end
  end

  assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> regRvalid);

  assert_rvalid_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> !regRvalid);

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !evtWrite |=> ($stable(sel0Reg) && $stable(sel1Reg)));

  assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrite |-> (!strobes.clearAll && !strobes.loadShadow));
endmodule

// File: rtl/dual_evt_ctr.sv
module dual_evt_ctr
  import dual_evt_ctr_pkg::*;
#(
  parameter int NUM_EVENTS = 128,
  parameter int LOW_W      = 32,
  parameter int UP_W       = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] evtIn,
  input  logic [1:0]            regAddr,
  input  logic                  regWr,
  input  logic [31:0]           regWdata,
  input  logic                  regRd,
  output logic [31:0]           regRdata,
  output logic                  regRvalid
);
  localparam int CNT_W = LOW_W + UP_W;

  ctlStrobes_t      strobes;
  logic [CNT_W-1:0] shadow0;
  logic [CNT_W-1:0] shadow1;

  dual_evt_ctr_ctrl #(
    .CNT_W(CNT_W),
    .LOW_W(LOW_W),
    .UP_W (UP_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regWdata (regWdata),
    .regRd    (regRd),
    .shadow0  (shadow0),
    .shadow1  (shadow1),
    .strobes  (strobes),
    .regRdata (regRdata),
    .regRvalid(regRvalid)
  );

  dual_evt_ctr_dp #(
    .NUM_EVENTS(NUM_EVENTS),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .evtIn  (evtIn),
    .strobes(strobes),
    .shadow0(shadow0),
    .shadow1(shadow1)
  );
endmodule

// File: tb/dual_evt_ctr_tb.sv
module dual_evt_ctr_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] evtIn = '0;
  logic [1:0]   regAddr = '0;
  logic         regWr = 1'b0;
  logic [31:0]  regWdata = '0;
  logic         regRd = 1'b0;
  logic [31:0]  regRdata;
  logic         regRvalid;
  logic [31:0]  smallRdata;
  logic         smallRvalid;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic [31:0] rdMain;
  logic [31:0] rdSmall;

  always #5 clk = ~clk;

  dual_evt_ctr u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRd(regRd), .regRdata(regRdata), .regRvalid(regRvalid)
  );

  // narrow instance: 6-bit low word, 2-bit high field, for carry and wrap
  dual_evt_ctr #(.NUM_EVENTS(8), .LOW_W(6), .UP_W(2)) u_small (
    .clk(clk), .rstN(rstN), .evtIn(evtIn[7:0]), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRd(regRd), .regRdata(smallRdata), .regRvalid(smallRvalid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    rdMain = regRdata;
    rdSmall = smallRdata;
  endtask

  task automatic pulse(input logic [127:0] mask, input int n);
    @(negedge clk);
    evtIn = mask;
    repeat (n) @(negedge clk);
    evtIn = '0;
  endtask

  function automatic logic [127:0] bitAt(input int i);
    logic [127:0] m = '0;
    m[i] = 1'b1;
    return m;
  endfunction

  task automatic t_reset();
    chk("R1 rvalid idle", 32'(regRvalid), 0);
    rd(2'd0); chk("R1 ctl", rdMain, 0);
    rd(2'd1); chk("R1 evt", rdMain, 0);
    rd(2'd2); chk("R1 low0", rdMain, 0);
    rd(2'd3); chk("R1 low1", rdMain, 0);
  endtask

  task automatic t_two_counters();
    wr(2'd1, {16'h0, 8'd104, 8'd40});
    wr(2'd0, 32'h5);
    pulse(bitAt(40), 7);
    pulse(bitAt(104), 3);
    pulse(bitAt(40) | bitAt(104), 2);
    wr(2'd0, 32'h2);
    rd(2'd2); chk("R2 counter0 selected event", rdMain, 9);
    rd(2'd3); chk("R12 counter1 independent", rdMain, 5);
  endtask

  task automatic t_bad_sel();
    wr(2'd1, {16'h0, 8'd104, 8'd200});
    wr(2'd0, 32'h5);
    pulse('1, 4);
    wr(2'd0, 32'h2);
    rd(2'd2); chk("R3 out-of-range selector", rdMain, 0);
    rd(2'd3); chk("R3 other counter still counts", rdMain, 4);
  endtask

  task automatic t_stop_hold();
    wr(2'd1, {16'h0, 8'd104, 8'd40});
    wr(2'd0, 32'h5);
    pulse(bitAt(40), 3);
    wr(2'd0, 32'h0);
    pulse(bitAt(40), 5);
    wr(2'd0, 32'h2);
    rd(2'd2); chk("R4 stopped counter holds", rdMain, 3);
  endtask

  task automatic t_clear_start();
    wr(2'd0, 32'h5);
    wr(2'd0, 32'h2);
    rd(2'd2); chk("R5 clear zeroes", rdMain, 0);
    wr(2'd0, 32'h5);
    pulse(bitAt(40), 1);
    wr(2'd0, 32'h2);
    rd(2'd2); chk("R5 counts from cycle after start", rdMain, 1);
  endtask

  task automatic t_same_edge_capture();
    wr(2'd0, 32'h5);
    pulse(bitAt(40), 2);
    @(negedge clk);
    evtIn = bitAt(40); regWr = 1'b1; regAddr = 2'd0; regWdata = 32'h2;
    @(negedge clk);
    evtIn = '0; regWr = 1'b0;
    rd(2'd2); chk("R6 capture includes same-edge event", rdMain, 3);
    pulse(bitAt(40), 4);
    wr(2'd0, 32'h2);
    rd(2'd2); chk("R6 0x2 stopped counting", rdMain, 3);
  endtask

  task automatic t_shadow_stable();
    wr(2'd0, 32'h5);
    pulse(bitAt(40), 4);
    wr(2'd0, 32'h3);
    pulse(bitAt(40), 6);
    rd(2'd2); chk("R7 shadow stable while live advances", rdMain, 4);
    wr(2'd0, 32'h2);
    rd(2'd2); chk("R7 next load updates", rdMain, 10);
  endtask

  task automatic t_ctl_readback();
    wr(2'd0, 32'h7);
    rd(2'd0); chk("R8 ctl reads enable only", rdMain, 1);
    wr(2'd0, 32'h0);
    rd(2'd0); chk("R8 ctl reads disabled", rdMain, 0);
  endtask

  task automatic t_read_timing();
    @(negedge clk);
    regRd = 1'b1; regAddr = 2'd1;
    chk("R10 rvalid low during strobe", 32'(regRvalid), 0);
    @(negedge clk);
    regRd = 1'b0;
    chk("R10 rvalid one cycle later", 32'(regRvalid), 1);
    @(negedge clk);
    chk("R10 rvalid single cycle", 32'(regRvalid), 0);
  endtask

  task automatic t_wrap();
    wr(2'd1, 32'h0000_0003);
    wr(2'd0, 32'h5);
    pulse(bitAt(3), 70);
    wr(2'd0, 32'h2);
    rd(2'd2); chk("R11 low word after carry", rdSmall, 6);
    rd(2'd1); chk("R11 high field after carry", rdSmall, 32'h0001_0003);
    wr(2'd1, 32'hFFFF_0003);
    rd(2'd1); chk("R9 high fields read-only", rdSmall, 32'h0001_0003);
    chk("R9 main event-control", rdMain, 32'h0000_0003);
    wr(2'd0, 32'h1);
    pulse(bitAt(3), 191);
    wr(2'd0, 32'h2);
    rd(2'd2); chk("R11 low word after wrap", rdSmall, 5);
    rd(2'd1); chk("R11 high field after wrap", rdSmall, 32'h0000_0003);
    rd(2'd2); chk("R11 wide counter no wrap", rdMain, 261);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_two_counters();
    t_bad_sel();
    t_stop_hold();
    t_clear_start();
    t_same_edge_capture();
    t_shadow_stable();
    t_ctl_readback();
    t_read_timing();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule